// File: doc/BRIEF.md
# Dual-Half Page ECC Engine

This block protects a 512-byte flash page with a single-error-correcting Hamming code. The page is split into two 256-byte halves, and each half has its own 3-byte code. The page bytes are offered on an input byte stream while the block is enabled. In generate mode the block accumulates parity and makes the two code words available for readout. In check mode the six stored code bytes follow the 512 data bytes on the same stream. The block then compares the stored codes with the recomputed ones and reports, for each half, one of three outcomes: clean, a single correctable bit error with its byte and bit location, or uncorrectable.

Results are read on a 32-bit output stream, and only while the access-mode control is held. A transfer on that stream while the enable is still set is a flush. A flush clears all accumulated state before a new page. The same transfer with the enable cleared returns results. In generate mode, successive result transfers alternate between the first-half code and the second-half code. In check mode every transfer returns the packed status of both halves. Correcting the data in memory is left to the consumer of these results.

The byte stream is refused (`byte_ready` low) for as long as access mode is held. Otherwise it is always accepted, and a byte moves on a cycle where valid and ready are both high. The result stream is valid exactly while access mode is held. Its word does not change while it waits for `res_ready`. A word is consumed on a cycle where valid and ready are both high.

Top module: `ecc_page_engine`

## Requirements
- R1: After reset, or after a flush, both generate-mode code words read 32'h00030000: all parity bits are zero, and the two unused code bits are one.
- R2: Code word layout (bits 23:0, with bits 31:24 reading zero). Bits 15:0 hold the line parity LP. For each address bit k of the byte offset within its half, LP[2k+1] is the XOR of the parities of all bytes whose offset has bit k set, and LP[2k] covers the bytes whose offset has bit k clear. Bits 23:18 hold the column parity CP. For j in 0..2, CP[2j+1] is the XOR over the half of all data bits whose bit index has bit j set, and CP[2j] covers the bit indices with bit j clear. Bits 17:16 read as 1.
- R3: With enable low and check mode low, successive result transfers return the first-half code, then the second-half code, and then repeat in that order.
- R4: Page bytes 0..255 feed the first half and bytes 256..511 feed the second half. In generate mode, any byte after the 512th has no effect on the codes.
- R5: A byte accepted while enable is low has no effect on any result.
- R6: A result transfer made while enable is high is a flush. It clears both accumulators, the byte position, the readout pointer and the stored codes.
- R7: In check mode, stream bytes 512..517 are taken as the stored codes in this order: first-half code bytes 0, 1, 2, then second-half code bytes 0, 1, 2. The status word puts the first half in bits 15:0 and the second half in bits 31:16.
- R8: A half whose stored and recomputed parity bits (LP and CP) all agree reports 16'h0000.
- R9: A half where each of the 11 parity pairs differs in exactly one bit reports a correctable error. Bit 14 is set, bits 10:8 give the failing bit index and bits 7:0 give the failing byte offset. All other bits are zero.
- R10: Any other disagreement in a half reports 16'h8000: the uncorrectable flag only, never together with the correctable flag.
- R11: `byte_ready` is low exactly while access mode is held, and `res_valid` follows access mode. A valid result word with `res_ready` low holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ecc_en | input | 1 | Enable: accumulate stream bytes; a result transfer while high is a flush |
| chk_mode | input | 1 | 0 = generate codes, 1 = check against stored codes |
| acc_mode | input | 1 | Access mode: stalls the byte stream and opens the result stream |
| byte_valid | input | 1 | Byte stream valid |
| byte_ready | output | 1 | Byte stream ready |
| byte_data | input | 8 | Byte stream data |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_data | output | 32 | Code word or packed two-half status |

## Verification
Each accepted byte updates the accumulators at the clock edge that accepts it. All results are combinational views of registered state. A byte's effect is therefore visible from the cycle after its acceptance, and a result word is valid in the same cycle that access mode and `res_ready` are raised. The bench changes the inputs on falling edges and compares each result one time unit after the falling edge of the cycle in which the transfer is made. That sample point falls after every byte of the page has been absorbed and before the transfer edge moves the readout pointer.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int N_HALVES   = 2;
  localparam int CODE_BYTES = 3;
  localparam int CODE_W     = 8 * CODE_BYTES;
  localparam int STAT_W     = 16;
  localparam int CP_W       = 6;

  localparam logic [STAT_W-1:0] STAT_CLEAN = 16'h0000;
  localparam logic [STAT_W-1:0] STAT_UNCOR = 16'h8000;
  localparam logic [1:0]        PAD_BITS   = 2'b11;
endpackage

// File: rtl/ecc_half_acc.sv
module ecc_half_acc
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          data,
  output logic [2*ADDR_W-1:0] lp,
  output logic [CP_W-1:0]     cp
);
  logic                par;
  logic [2*ADDR_W-1:0] lp_step;
  logic [CP_W-1:0]     cp_step;

  always_comb begin
    par = ^data;
    for (int k = 0; k < ADDR_W; k++) begin
      lp_step[2*k+1] = par & addr[k];
      lp_step[2*k]   = par & ~addr[k];
    end
    cp_step = '0;
    for (int j = 0; j < CP_W/2; j++) begin
      for (int b = 0; b < 8; b++) begin
        if (((b >> j) & 1) == 1) cp_step[2*j+1] = cp_step[2*j+1] ^ data[b];
        else                     cp_step[2*j]   = cp_step[2*j]   ^ data[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp <= '0;
      cp <= '0;
    end else if (clr) begin
      lp <= '0;
      cp <= '0;
    end else if (en) begin
      lp <= lp ^ lp_step;
      cp <= cp ^ cp_step;
    end
  end
endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [2*ADDR_W-1:0] lp_ref,
  input  logic [CP_W-1:0]     cp_ref,
  input  logic [2*ADDR_W-1:0] lp_calc,
  input  logic [CP_W-1:0]     cp_calc,
  output logic [STAT_W-1:0]   status
);
  localparam int U_W    = 2*ADDR_W + CP_W;
  localparam int PAIRS  = U_W / 2;

  logic [U_W-1:0]   diff;
  logic [PAIRS-1:0] mixed;
  logic [7:0]       byte_idx;
  logic [2:0]       bit_idx;

  always_comb begin
    diff = {cp_ref ^ cp_calc, lp_ref ^ lp_calc};
    for (int i = 0; i < PAIRS; i++) mixed[i] = diff[2*i] ^ diff[2*i+1];
    byte_idx = '0;
    for (int k = 0; k < ADDR_W; k++) byte_idx[k] = diff[2*k+1];
    for (int j = 0; j < 3; j++) bit_idx[j] = diff[2*ADDR_W + 2*j + 1];

    if (diff == '0)   status = STAT_CLEAN;
    else if (&mixed)  status = {2'b01, 3'b000, bit_idx, byte_idx};
    else              status = STAT_UNCOR;
  end
endmodule

// File: rtl/ecc_ctrl.sv
module ecc_ctrl
  import ecc_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ecc_en,
  input  logic                          chk_mode,
  input  logic                          acc_mode,
  input  logic                          byte_valid,
  input  logic [7:0]                    byte_data,
  input  logic                          res_ready,
  output logic [N_HALVES-1:0]           half_en,
  output logic [ADDR_W-1:0]             addr,
  output logic                          clr,
  output logic                          ptr,
  output logic [N_HALVES*CODE_W-1:0]    stored_flat
);
  localparam int STORE_N = N_HALVES * CODE_BYTES;
  localparam int LIMIT   = PAGE_BYTES + STORE_N;
  localparam int SEL_W   = CNT_W - ADDR_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] off;
  logic [SEL_W-1:0] sel;
  logic             take, rd_adv, in_page, in_store;
  logic [7:0]       stored [STORE_N];

  assign take     = byte_valid && !acc_mode && ecc_en;
  assign clr      = acc_mode && res_ready && ecc_en;
  assign rd_adv   = acc_mode && res_ready && !ecc_en && !chk_mode;
  assign in_page  = cnt < CNT_W'(PAGE_BYTES);
  assign in_store = !in_page && (cnt < CNT_W'(LIMIT));
  assign off      = cnt - CNT_W'(PAGE_BYTES);
  assign sel      = cnt[CNT_W-1:ADDR_W];
  assign addr     = cnt[ADDR_W-1:0];

  for (genvar h = 0; h < N_HALVES; h++) begin : g_en
    assign half_en[h] = take && in_page && (sel == SEL_W'(h));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ptr <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      ptr <= 1'b0;
    end else begin
      if (take && cnt < CNT_W'(LIMIT)) cnt <= cnt + CNT_W'(1);
      if (rd_adv) ptr <= ~ptr;
    end
  end

  for (genvar s = 0; s < STORE_N; s++) begin : g_store
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        stored[s] <= '0;
      else if (clr)                                      stored[s] <= '0;
      else if (take && chk_mode && in_store && off == CNT_W'(s)) stored[s] <= byte_data;
    end
    assign stored_flat[8*s +: 8] = stored[s];
  end
endmodule

// File: rtl/ecc_page_engine.sv
module ecc_page_engine
  import ecc_pkg::*;
#(
  parameter int PAGE_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ecc_en,
  input  logic        chk_mode,
  input  logic        acc_mode,
  input  logic        byte_valid,
  output logic        byte_ready,
  input  logic [7:0]  byte_data,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [31:0] res_data
);
  localparam int HALF_BYTES = PAGE_BYTES / N_HALVES;
  localparam int ADDR_W     = $clog2(HALF_BYTES);
  localparam int CNT_W      = $clog2(PAGE_BYTES + N_HALVES*CODE_BYTES + 1);

  logic [N_HALVES-1:0]        half_en;
  logic [ADDR_W-1:0]          addr;
  logic                       clr, ptr;
  logic [N_HALVES*CODE_W-1:0] stored_flat;
  logic [N_HALVES*CODE_W-1:0] code_flat;
  logic [N_HALVES*STAT_W-1:0] stat_flat;

  assign byte_ready = !acc_mode;
  assign res_valid  = acc_mode;

  ecc_ctrl #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .chk_mode(chk_mode),
    .acc_mode(acc_mode), .byte_valid(byte_valid), .byte_data(byte_data),
    .res_ready(res_ready), .half_en(half_en), .addr(addr), .clr(clr),
    .ptr(ptr), .stored_flat(stored_flat)
  );

  for (genvar h = 0; h < N_HALVES; h++) begin : g_half
    logic [2*ADDR_W-1:0] lp;
    logic [CP_W-1:0]     cp;

    ecc_half_acc #(.ADDR_W(ADDR_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(half_en[h]),
      .addr(addr), .data(byte_data), .lp(lp), .cp(cp)
    );

    assign code_flat[CODE_W*h +: CODE_W] = {cp, PAD_BITS, lp};

    ecc_syndrome #(.ADDR_W(ADDR_W)) u_syn (
      .lp_ref (stored_flat[CODE_W*h +: 2*ADDR_W]),
      .cp_ref (stored_flat[CODE_W*h + 2*ADDR_W + 2 +: CP_W]),
      .lp_calc(lp),
      .cp_calc(cp),
      .status (stat_flat[STAT_W*h +: STAT_W])
    );
  end

  always_comb begin
    if (chk_mode) res_data = stat_flat;
    else          res_data = {8'h00, code_flat[CODE_W*ptr +: CODE_W]};
  end
endmodule

// File: rtl/ecc_page_engine_chk.sv
module ecc_page_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ecc_en,
  input logic        chk_mode,
  input logic        acc_mode,
  input logic        byte_ready,
  input logic        res_valid,
  input logic        res_ready,
  input logic [31:0] res_data
);
  p_stall_bytes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mode |-> !byte_ready);

  p_hold_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(res_valid && !res_ready) && chk_mode == $past(chk_mode))
      |-> res_data == $past(res_data));

  p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && chk_mode) |-> !(res_data[15] && res_data[14]) && !(res_data[31] && res_data[30]));

  p_uncor_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && chk_mode && res_data[15]) |-> res_data[14:0] == 15'd0);

  p_code_layout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !chk_mode) |-> res_data[31:24] == 8'h00 && res_data[17:16] == 2'b11);

  p_flush_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ecc_en && acc_mode && res_ready) && acc_mode && !chk_mode)
      |-> res_data == 32'h0003_0000);
endmodule

bind ecc_page_engine ecc_page_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .chk_mode(chk_mode),
  .acc_mode(acc_mode), .byte_ready(byte_ready), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data)
);

// File: tb/ecc_page_engine_tb.sv
module ecc_page_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        ecc_en = 0, chk_mode = 0, acc_mode = 0;
  logic        byte_valid = 0, res_ready = 0;
  logic [7:0]  byte_data = 0;
  logic        byte_ready, res_valid;
  logic [31:0] res_data;

  int n_checks = 0, n_fail = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [7:0]  pg [512];

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_page_engine u_dut (
    .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .chk_mode(chk_mode),
    .acc_mode(acc_mode), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each result transfer made with enable low
  always @(negedge clk) begin
    #1;
    if (rst_n && res_valid && res_ready && !ecc_en) begin
      if (exp_q.size() == 0) check(res_data, 32'hxxxx_xxxx, "R3 unexpected transfer");
      else check(res_data, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  function automatic logic [23:0] ref_code(input int h);
    logic [15:0] lp = '0;
    logic [5:0]  cp = '0;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d = pg[h*256 + i];
      logic p = ^d;
      for (int k = 0; k < 8; k++)
        if (i[k]) lp[2*k+1] ^= p; else lp[2*k] ^= p;
      for (int b = 0; b < 8; b++)
        if (d[b])
          for (int j = 0; j < 3; j++)
            if (((b >> j) & 1) == 1) cp[2*j+1] ^= 1'b1; else cp[2*j] ^= 1'b1;
    end
    return {cp, 2'b11, lp};
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < 512; i++) pg[i] = 8'((i*29 + seed*7) ^ (i >> 2) ^ (seed << 3));
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk); byte_valid = 1; byte_data = d;
  endtask

  task automatic idle;
    @(negedge clk); byte_valid = 0; acc_mode = 0; res_ready = 0;
  endtask

  task automatic flush;
    @(negedge clk); byte_valid = 0; ecc_en = 1; acc_mode = 1; res_ready = 1;
    @(negedge clk); res_ready = 0; acc_mode = 0;
  endtask

  task automatic stream_page(input int n);
    for (int i = 0; i < n; i++) send(i < 512 ? pg[i] : 8'hA5);
    @(negedge clk); byte_valid = 0;
  endtask

  task automatic send_codes(input logic [47:0] cw);
    for (int i = 0; i < 6; i++) send(cw[8*i +: 8]);
    @(negedge clk); byte_valid = 0;
  endtask

  task automatic open_read;
    @(negedge clk); ecc_en = 0; acc_mode = 1;
  endtask

  task automatic rd(input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); res_ready = 1;
    @(negedge clk); res_ready = 0;
  endtask

  task automatic gen_page(input int n, input string tag);
    chk_mode = 0;
    flush;
    stream_page(n);
    open_read;
    rd({8'h0, ref_code(0)}, {tag, " half0 code"});
    rd({8'h0, ref_code(1)}, {tag, " half1 code"});
  endtask

  task automatic chk_page(input logic [47:0] cw, input logic [31:0] exp, input string tag);
    idle;
    chk_mode = 1;
    flush;
    stream_page(512);
    send_codes(cw);
    open_read;
    rd(exp, tag);
    idle;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] good;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state, R11 handshake
    open_read;
    #1;
    check({31'd0, byte_ready}, 32'd0, "R11 byte_ready low in access mode");
    check({31'd0, res_valid},  32'd1, "R11 res_valid in access mode");
    rd(32'h0003_0000, "R1 reset half0 code");
    rd(32'h0003_0000, "R1 reset half1 code");
    idle;
    #1;
    check({31'd0, byte_ready}, 32'd1, "R11 byte_ready high outside access mode");

    // R2/R3/R4 two data patterns
    fill(1);   gen_page(512, "R2 pattern A");
    rd({8'h0, ref_code(0)}, "R3 order wraps to half0");
    idle;
    for (int i = 0; i < 512; i++) pg[i] = 8'hFF;
    gen_page(512, "R2 all ones");
    idle;

    // R5 bytes with enable low ignored
    fill(3); gen_page(512, "R4 pattern C");
    idle;
    ecc_en = 0;
    for (int i = 0; i < 10; i++) send(8'(i*13 + 1));
    idle;
    open_read;
    rd({8'h0, ref_code(0)}, "R5 half0 unchanged");
    rd({8'h0, ref_code(1)}, "R5 half1 unchanged");
    idle;

    // R4 bytes past the page ignored
    fill(4); gen_page(520, "R4 overlong page");
    rd({8'h0, ref_code(0)}, "R3 pointer to half0");
    idle;

    // R6 flush clears accumulators and pointer (pointer left at half1 above)
    flush;
    open_read;
    rd(32'h0003_0000, "R6 flush half0");
    rd(32'h0003_0000, "R6 flush half1");
    idle;

    // check path
    fill(5);
    good = {ref_code(1), ref_code(0)};
    chk_page(good, 32'h0000_0000, "R8 clean page");

    pg[37] ^= 8'h20;
    chk_page(good, 32'h0000_4525, "R9 half0 byte37 bit5");
    pg[37] ^= 8'h20;

    pg[0] ^= 8'h01; pg[511] ^= 8'h80;
    chk_page(good, 32'h47FF_4000, "R7 R9 both halves single");
    pg[0] ^= 8'h01; pg[511] ^= 8'h80;

    pg[10] ^= 8'h02; pg[20] ^= 8'h08;
    chk_page(good, 32'h0000_8000, "R10 double error half0");
    pg[10] ^= 8'h02; pg[20] ^= 8'h08;

    chk_page(good ^ 48'h0000_0400_0000, "R10 stored code bit flip half1" == "" ? 32'h0 : 32'h8000_0000,
             "R10 stored code bit flip half1");

    repeat (4) @(negedge clk);
    check(exp_q.size(), 0, "R3 all expected transfers seen");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule